// File: doc/BRIEF.md
# Software-Sequenced Fast-Page DRAM Strobe Bridge

This block sits between a DSP bus that has separate X and Y data spaces and a bank of fast-page-mode DRAM devices. It holds no sequencer that runs on its own. Software drives every DRAM phase by touching two decoded address windows. In the row window, an X-space write opens a row and a Y-space write closes it. In the column window, any access fires one column strobe burst. The low address bits go straight to the multiplexed DRAM address lines. All six 4-bit devices that form a 24-bit word share the one set of active-low strobes.

A long-word write puts the X and Y selects together on one row-window address. The bridge treats this as a RAS-only refresh: it opens that row for a short fixed time and then closes it without any column strobe. Write-enable is a delayed copy of the write request and is placed inside the column strobe. A precharge timer holds back a row open that comes too early and flags it. A column access made with no open row is refused and flagged.

The controller has five named states. ROW_IDLE: the row is closed. ROW_PEND: an open was requested during precharge and is waiting for the timer. ROW_OPEN: the page is open. COL_BURST: the column strobe is active. REF_PULSE: a refresh is in progress. Transitions:
- ROW_IDLE to ROW_OPEN on an open request when precharge is done.
- ROW_IDLE to ROW_PEND on an open request that comes early.
- ROW_IDLE to REF_PULSE on a refresh request when precharge is done.
- ROW_PEND to ROW_OPEN or REF_PULSE when the timer expires.
- ROW_PEND to ROW_IDLE on a close request.
- ROW_OPEN to ROW_IDLE on a close request.
- ROW_OPEN to COL_BURST on a column access.
- COL_BURST to ROW_OPEN after CAS_CYC cycles.
- REF_PULSE to ROW_IDLE after REF_CYC cycles.

Top module: `dram_page_bridge`

## Requirements
- R1: A bus access with `bus_addr[15:10]` equal to ROW_WIN (default 6'h3E) is a row-window access, and one equal to COL_WIN (default 6'h3F) is a column-window access. An access in neither window changes no output.
- R2: A row-window write with `bus_xsel`=1 and `bus_ysel`=0 opens the row. From the next cycle `ras_n`=0 and `dram_addr`=`bus_addr[9:0]`, and `ras_n` stays low until a close. A row-window read has no effect, and an open request while the row is open has no effect.
- R3: A row-window write with `bus_ysel`=1 and `bus_xsel`=0 while the row is open drives `ras_n` high from the next cycle.
- R4: A column-window access (read or write) while the row is open drives `cas_n` low for CAS_CYC (default 3) cycles from the next cycle, with `dram_addr`=`bus_addr[9:0]`. After that the row stays open.
- R5: For a column write, `we_n` is low from WE_DLY (default 1) cycles after `cas_n` falls until `cas_n` rises. A column read leaves `we_n` high. `we_n` is never low while `cas_n` is high.
- R6: A row-window write with both `bus_xsel` and `bus_ysel` set is a refresh. `ras_n` is low for REF_CYC (default 2) cycles with `dram_addr` set to the row, then goes high, and `cas_n` stays high.
- R7: `cas_n` is low only while `ras_n` is low. A column-window access while no row is open gives no CAS and sets the sticky `col_err` flag.
- R8: Once `ras_n` rises it stays high for at least TRP_CYC+1 (default 4) cycles. An open or refresh request that comes earlier is deferred until this time has passed, and it sets the sticky `prech_viol` flag.
- R9: While `rst_n`=0 and after reset, `ras_n`, `cas_n` and `we_n` are 1, `dram_addr` is 0, both flags are 0 and the precharge time counts as already met.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | One-cycle bus access strobe |
| bus_addr | input | 16 | Processor word address |
| bus_xsel | input | 1 | Access targets X space |
| bus_ysel | input | 1 | Access targets Y space |
| bus_write | input | 1 | 1 = write, 0 = read |
| dram_addr | output | 10 | Multiplexed row/column address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Delayed write enable, active low |
| col_err | output | 1 | Sticky: column access with row closed |
| prech_viol | output | 1 | Sticky: row open requested during precharge |

## Verification
Several properties are checked by assertions on every cycle. CAS never appears without RAS, and write-enable never appears without CAS. RAS stays high for the full precharge time. A close or a closed-row column access gives the right strobe level one cycle later. A valid refresh raises RAS with no CAS. Other behaviour can only be shown by the bench's scenarios: the exact length of the CAS and refresh pulses, where the delayed write-enable falls inside CAS, the address placed on the DRAM lines, deferral of an early open, that stray, read and repeated-open accesses have no effect, and that the flags stay set until reset.

// File: rtl/dram_bridge_pkg.sv
package dram_bridge_pkg;

    typedef enum logic [2:0] {
        ROW_IDLE  = 3'd0,
        ROW_PEND  = 3'd1,
        ROW_OPEN  = 3'd2,
        COL_BURST = 3'd3,
        REF_PULSE = 3'd4
    } brg_state_t;

    typedef struct packed {
        logic open_req;
        logic close_req;
        logic ref_req;
        logic col_req;
    } brg_req_t;

endpackage

// File: rtl/dram_win_decode.sv
module dram_win_decode
    import dram_bridge_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int COL_W   = 10,
    parameter int ROW_WIN = 'h3E,
    parameter int COL_WIN = 'h3F
) (
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_xsel,
    input  logic              bus_ysel,
    input  logic              bus_write,
    output brg_req_t          req
);
    localparam int WIN_W = ADDR_W - COL_W;
    localparam logic [WIN_W-1:0] ROW_TAG = WIN_W'(ROW_WIN);
    localparam logic [WIN_W-1:0] COL_TAG = WIN_W'(COL_WIN);

    logic [WIN_W-1:0] tag;
    logic             in_row;
    logic             in_col;
    logic             row_wr;

    always_comb begin
        tag    = bus_addr[ADDR_W-1:COL_W];
        in_row = bus_valid && (tag == ROW_TAG);
        in_col = bus_valid && (tag == COL_TAG);
        row_wr = in_row && bus_write;

        req.ref_req   = row_wr && bus_xsel && bus_ysel;
        req.open_req  = row_wr && bus_xsel;
        req.close_req = row_wr && bus_ysel;
        req.col_req   = in_col;
    end

    always_comb begin
        assert (!(req.col_req && (req.open_req || req.close_req)))
            else $error("assert_windows_disjoint_R1");
    end
endmodule

// File: rtl/dram_prech_timer.sv
module dram_prech_timer #(
    parameter int TRP_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ras_close,
    output logic ready
);
    localparam int CNT_W = $clog2(TRP_CYC + 2);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TRP_CYC);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= LIMIT;
        end else if (ras_close) begin
            cnt <= '0;
        end else if (cnt < LIMIT) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign ready = (cnt >= LIMIT);

    ap_ready_after_close_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ras_close |=> !ready)
        else $error("assert_ready_after_close_R8");
endmodule

// File: rtl/dram_we_delay.sv
module dram_we_delay #(
    parameter int WE_DLY = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_in,
    output logic wr_out
);
    generate
        if (WE_DLY == 0) begin : g_direct
            assign wr_out = wr_in;
        end else begin : g_pipe
            logic [WE_DLY-1:0] stage;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage <= '0;
                end else begin
                    for (int i = WE_DLY - 1; i > 0; i--) begin
                        stage[i] <= stage[i-1];
                    end
                    stage[0] <= wr_in;
                end
            end
            assign wr_out = stage[WE_DLY-1];
        end
    endgenerate
endmodule

// File: rtl/dram_page_bridge.sv
module dram_page_bridge
    import dram_bridge_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int COL_W   = 10,
    parameter int ROW_WIN = 'h3E,
    parameter int COL_WIN = 'h3F,
    parameter int TRP_CYC = 3,
    parameter int CAS_CYC = 3,
    parameter int WE_DLY  = 1,
    parameter int REF_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_xsel,
    input  logic              bus_ysel,
    input  logic              bus_write,
    output logic [COL_W-1:0]  dram_addr,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic              col_err,
    output logic              prech_viol
);
    localparam int MAX_CYC = (CAS_CYC > REF_CYC) ? CAS_CYC : REF_CYC;
    localparam int CYC_W   = $clog2(MAX_CYC + 1);
    localparam logic [CYC_W-1:0] CAS_LAST = CYC_W'(CAS_CYC - 1);
    localparam logic [CYC_W-1:0] REF_LAST = CYC_W'(REF_CYC - 1);
    localparam int HI_W    = $clog2(TRP_CYC + 3);
    localparam logic [HI_W-1:0] HI_MIN = HI_W'(TRP_CYC + 1);

    brg_state_t        state;
    brg_state_t        state_nxt;
    brg_req_t          req;
    logic              ready;
    logic              ras_close;
    logic              ras_on;
    logic              ras_on_nxt;
    logic [CYC_W-1:0]  cyc_cnt;
    logic [COL_W-1:0]  pend_row;
    logic              pend_ref;
    logic              col_wr;
    logic              wr_req;
    logic              wr_dly;
    logic              load_bus;
    logic              load_pend;
    logic              set_cerr;
    logic              set_viol;
    logic              defer;

    dram_win_decode #(
        .ADDR_W (ADDR_W),
        .COL_W  (COL_W),
        .ROW_WIN(ROW_WIN),
        .COL_WIN(COL_WIN)
    ) u_dec (
        .bus_valid(bus_valid),
        .bus_addr (bus_addr),
        .bus_xsel (bus_xsel),
        .bus_ysel (bus_ysel),
        .bus_write(bus_write),
        .req      (req)
    );

    dram_prech_timer #(
        .TRP_CYC(TRP_CYC)
    ) u_prech (
        .clk      (clk),
        .rst_n    (rst_n),
        .ras_close(ras_close),
        .ready    (ready)
    );

    dram_we_delay #(
        .WE_DLY(WE_DLY)
    ) u_wedly (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_in (wr_req),
        .wr_out(wr_dly)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ROW_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Next-state and request handling
    always_comb begin
        state_nxt = state;
        load_bus  = 1'b0;
        load_pend = 1'b0;
        set_cerr  = 1'b0;
        set_viol  = 1'b0;
        defer     = 1'b0;
        unique case (state)
            ROW_IDLE: begin
                if (req.open_req) begin
                    if (ready) begin
                        state_nxt = req.ref_req ? REF_PULSE : ROW_OPEN;
                        load_bus  = 1'b1;
                    end else begin
                        state_nxt = ROW_PEND;
                        defer     = 1'b1;
                        set_viol  = 1'b1;
                    end
                end else if (req.col_req) begin
                    set_cerr = 1'b1;
                end
            end
            ROW_PEND: begin
                if (req.close_req && !req.open_req) begin
                    state_nxt = ROW_IDLE;
                end else if (ready) begin
                    state_nxt = pend_ref ? REF_PULSE : ROW_OPEN;
                    load_pend = 1'b1;
                end
                if (req.col_req) begin
                    set_cerr = 1'b1;
                end
            end
            ROW_OPEN: begin
                if (req.close_req) begin
                    state_nxt = ROW_IDLE;
                end else if (req.col_req) begin
                    state_nxt = COL_BURST;
                    load_bus  = 1'b1;
                end
            end
            COL_BURST: begin
                if (cyc_cnt == CAS_LAST) begin
                    state_nxt = ROW_OPEN;
                end
            end
            REF_PULSE: begin
                if (cyc_cnt == REF_LAST) begin
                    state_nxt = ROW_IDLE;
                end
            end
            default: state_nxt = ROW_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dram_addr  <= '0;
            pend_row   <= '0;
            pend_ref   <= 1'b0;
            cyc_cnt    <= '0;
            col_wr     <= 1'b0;
            col_err    <= 1'b0;
            prech_viol <= 1'b0;
        end else begin
            if (load_bus) begin
                dram_addr <= bus_addr[COL_W-1:0];
                col_wr    <= bus_write;
            end else if (load_pend) begin
                dram_addr <= pend_row;
            end
            if (defer) begin
                pend_row <= bus_addr[COL_W-1:0];
                pend_ref <= req.ref_req;
            end
            if (state_nxt != state) begin
                cyc_cnt <= '0;
            end else if (cyc_cnt < CYC_W'(MAX_CYC)) begin
                cyc_cnt <= cyc_cnt + 1'b1;
            end
            if (set_cerr) begin
                col_err <= 1'b1;
            end
            if (set_viol) begin
                prech_viol <= 1'b1;
            end
        end
    end

    // Output decode
    always_comb begin
        ras_on     = (state == ROW_OPEN) || (state == COL_BURST) || (state == REF_PULSE);
        ras_on_nxt = (state_nxt == ROW_OPEN) || (state_nxt == COL_BURST) ||
                     (state_nxt == REF_PULSE);
        ras_close  = ras_on && !ras_on_nxt;
        wr_req     = (state == COL_BURST) && col_wr;
        ras_n      = !ras_on;
        cas_n      = !(state == COL_BURST);
        we_n       = !((state == COL_BURST) && wr_dly);
    end

    // Checks
    logic [HI_W-1:0] hi_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= HI_MIN;
        end else if (ras_n) begin
            if (hi_cnt < HI_MIN) begin
                hi_cnt <= hi_cnt + 1'b1;
            end
        end else begin
            hi_cnt <= '0;
        end
    end

    assert_cas_under_ras_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n)
        else $error("assert_cas_under_ras_R7");

    assert_closed_col_refused_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req.col_req && ras_n) |=> (cas_n && col_err))
        else $error("assert_closed_col_refused_R7");

    assert_we_inside_cas_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> !cas_n)
        else $error("assert_we_inside_cas_R5");

    assert_precharge_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (hi_cnt >= HI_MIN))
        else $error("assert_precharge_kept_R8");

    assert_close_drops_ras_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ROW_OPEN && req.close_req) |=> ras_n)
        else $error("assert_close_drops_ras_R3");

    assert_refresh_no_cas_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ROW_IDLE && req.ref_req && ready) |=> (!ras_n && cas_n))
        else $error("assert_refresh_no_cas_R6");
endmodule

// File: tb/tb_dram_page_bridge.sv
module tb_dram_page_bridge;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_valid;
    logic [15:0] bus_addr;
    logic        bus_xsel;
    logic        bus_ysel;
    logic        bus_write;
    logic [9:0]  dram_addr;
    logic        ras_n;
    logic        cas_n;
    logic        we_n;
    logic        col_err;
    logic        prech_viol;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    dram_page_bridge dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_addr  (bus_addr),
        .bus_xsel  (bus_xsel),
        .bus_ysel  (bus_ysel),
        .bus_write (bus_write),
        .dram_addr (dram_addr),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .col_err   (col_err),
        .prech_viol(prech_viol)
    );

    typedef struct packed {
        logic       v;
        logic [1:0] win;   // 0 none, 1 row window, 2 column window
        logic       x;
        logic       y;
        logic       wr;
        logic [9:0] a;
        logic       e_ras;
        logic       e_cas;
        logic       e_we;
        logic [9:0] e_addr;
        logic       e_cerr;
        logic       e_viol;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t TBL [NV] = '{
        // open row 0x155 (R2)
        {1'b1,2'd1,1'b1,1'b0,1'b1,10'h155, 1'b0,1'b1,1'b1,10'h155,1'b0,1'b0},
        {1'b0,2'd0,1'b0,1'b0,1'b0,10'h000, 1'b0,1'b1,1'b1,10'h155,1'b0,1'b0},
        // column write 0x0AA (R4, R5)
        {1'b1,2'd2,1'b0,1'b1,1'b1,10'h0AA, 1'b0,1'b0,1'b1,10'h0AA,1'b0,1'b0},
        {1'b0,2'd0,1'b0,1'b0,1'b0,10'h000, 1'b0,1'b0,1'b0,10'h0AA,1'b0,1'b0},
        {1'b0,2'd0,1'b0,1'b0,1'b0,10'h000, 1'b0,1'b0,1'b0,10'h0AA,1'b0,1'b0},
        {1'b0,2'd0,1'b0,1'b0,1'b0,10'h000, 1'b0,1'b1,1'b1,10'h0AA,1'b0,1'b0},
        // column read 0x011 (R4, R5)
        {1'b1,2'd2,1'b1,1'b0,1'b0,10'h011, 1'b0,1'b0,1'b1,10'h011,1'b0,1'b0},
        {1'b0,2'd0,1'b0,1'b0,1'b0,10'h000, 1'b0,1'b0,1'b1,10'h011,1'b0,1'b0},
        {1'b0,2'd0,1'b0,1'b0,1'b0,10'h000, 1'b0,1'b0,1'b1,10'h011,1'b0,1'b0},
        {1'b0,2'd0,1'b0,1'b0,1'b0,10'h000, 1'b0,1'b1,1'b1,10'h011,1'b0,1'b0},
        // close (R3)
        {1'b1,2'd1,1'b0,1'b1,1'b1,10'h000, 1'b1,1'b1,1'b1,10'h011,1'b0,1'b0},
        // early open 0x0F0 deferred (R8)
        {1'b1,2'd1,1'b1,1'b0,1'b1,10'h0F0, 1'b1,1'b1,1'b1,10'h011,1'b0,1'b1},
        {1'b0,2'd0,1'b0,1'b0,1'b0,10'h000, 1'b1,1'b1,1'b1,10'h011,1'b0,1'b1},
        {1'b0,2'd0,1'b0,1'b0,1'b0,10'h000, 1'b1,1'b1,1'b1,10'h011,1'b0,1'b1},
        {1'b0,2'd0,1'b0,1'b0,1'b0,10'h000, 1'b0,1'b1,1'b1,10'h0F0,1'b0,1'b1},
        // close, then column with row closed (R7)
        {1'b1,2'd1,1'b0,1'b1,1'b1,10'h000, 1'b1,1'b1,1'b1,10'h0F0,1'b0,1'b1},
        {1'b1,2'd2,1'b1,1'b0,1'b0,10'h3FF, 1'b1,1'b1,1'b1,10'h0F0,1'b1,1'b1},
        {1'b0,2'd0,1'b0,1'b0,1'b0,10'h000, 1'b1,1'b1,1'b1,10'h0F0,1'b1,1'b1},
        {1'b0,2'd0,1'b0,1'b0,1'b0,10'h000, 1'b1,1'b1,1'b1,10'h0F0,1'b1,1'b1},
        // long-word refresh of row 0x2C3 (R6)
        {1'b1,2'd1,1'b1,1'b1,1'b1,10'h2C3, 1'b0,1'b1,1'b1,10'h2C3,1'b1,1'b1},
        {1'b0,2'd0,1'b0,1'b0,1'b0,10'h000, 1'b0,1'b1,1'b1,10'h2C3,1'b1,1'b1},
        {1'b0,2'd0,1'b0,1'b0,1'b0,10'h000, 1'b1,1'b1,1'b1,10'h2C3,1'b1,1'b1},
        {1'b0,2'd0,1'b0,1'b0,1'b0,10'h000, 1'b1,1'b1,1'b1,10'h2C3,1'b1,1'b1}
    };

    function automatic logic [15:0] mk_addr(input logic [1:0] win, input logic [9:0] a);
        logic [5:0] tag;
        tag = (win == 2'd1) ? 6'h3E : (win == 2'd2) ? 6'h3F : 6'h05;
        return {tag, a};
    endfunction

    task automatic drive(input logic v, input logic [1:0] win, input logic x,
                         input logic y, input logic wr, input logic [9:0] a);
        bus_valid = v;
        bus_addr  = mk_addr(win, a);
        bus_xsel  = x;
        bus_ysel  = y;
        bus_write = wr;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [14:0] act, input logic [14:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got ras=%b cas=%b we=%b addr=%h cerr=%b viol=%b, expected ras=%b cas=%b we=%b addr=%h cerr=%b viol=%b",
                     req, act[14], act[13], act[12], act[11:2], act[1], act[0],
                     exp[14], exp[13], exp[12], exp[11:2], exp[1], exp[0]);
        end
    endtask

    function automatic logic [14:0] outs();
        return {ras_n, cas_n, we_n, dram_addr, col_err, prech_viol};
    endfunction

    logic [14:0] held;

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got running, expected finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stim
        rst_n = 1'b0;
        drive(1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 10'h0);
        step();
        // R9: reset state while in reset
        check("R9 in reset", outs(), {1'b1,1'b1,1'b1,10'h000,1'b0,1'b0});
        step();
        rst_n = 1'b1;
        step();
        check("R9 after reset", outs(), {1'b1,1'b1,1'b1,10'h000,1'b0,1'b0});

        // table walk: R2 R3 R4 R5 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].v, TBL[i].win, TBL[i].x, TBL[i].y, TBL[i].wr, TBL[i].a);
            step();
            check($sformatf("R2-table row %0d", i), outs(),
                  {TBL[i].e_ras, TBL[i].e_cas, TBL[i].e_we, TBL[i].e_addr,
                   TBL[i].e_cerr, TBL[i].e_viol});
        end

        // R1: access outside both windows changes nothing
        drive(1'b1, 2'd0, 1'b1, 1'b0, 1'b1, 10'h123);
        held = outs();
        step();
        check("R1 outside window", outs(), held);

        // R2: row-window read has no effect
        drive(1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 10'h1AB);
        step();
        check("R2 row read ignored", outs(), held);

        // R2: open, then a second open while open is ignored
        drive(1'b1, 2'd1, 1'b1, 1'b0, 1'b1, 10'h001);
        step();
        check("R2 open 0x001", outs(), {1'b0,1'b1,1'b1,10'h001,1'b1,1'b1});
        drive(1'b1, 2'd1, 1'b1, 1'b0, 1'b1, 10'h002);
        step();
        check("R2 reopen ignored", outs(), {1'b0,1'b1,1'b1,10'h001,1'b1,1'b1});

        // R1: non-window access with open row gives no CAS
        drive(1'b1, 2'd0, 1'b0, 1'b1, 1'b1, 10'h3C0);
        step();
        check("R1 outside window no CAS", outs(), {1'b0,1'b1,1'b1,10'h001,1'b1,1'b1});
        drive(1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 10'h0);

        // R9: reset clears strobes and sticky flags
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        step();
        check("R9 flags cleared", outs(), {1'b1,1'b1,1'b1,10'h000,1'b0,1'b0});

        // R8: right after reset an open is accepted at once
        drive(1'b1, 2'd1, 1'b1, 1'b0, 1'b1, 10'h077);
        step();
        check("R8 open after reset", outs(), {1'b0,1'b1,1'b1,10'h077,1'b0,1'b0});
        drive(1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 10'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule